// File: doc/BRIEF.md
# Page-Table Refill Walker

This block services translation-buffer misses in hardware. The requester hands it a faulting virtual address, an instruction/data flag, a cause code and a flag that says whether the translation buffer should be written. From these it forms the virtual address of the page-table entry. That address is sent through the data translation port as a ring-0 data read with refill disabled, so a miss there is never walked again. The block then fetches the 32-bit entry over a valid/ready memory port.

On success the entry is written into one of four ways, and the ring of the new mapping is taken from the entry itself. The way comes from a rotating refill counter that is advanced before use. The faulting address is recorded in the exception-address output. A request whose cause is not a plain miss, or whose entry address fails to translate, completes at once with a fault status and touches nothing.

Only one walk is in flight at a time. The requester sees a one-cycle completion pulse that carries the fault flag, the fault cause, the fetched entry and its ring.

Top module: `pte_refill_walker`

## Requirements
- R1: The entry address driven on `xlateVaddr` while `xlateValid` is high equals (`ptBase` OR (faulting address shifted right by 10)) with bits 1:0 cleared.
- R2: A request whose `missCause` differs from the miss code 1 issues no translation, no memory request and no write. It completes with `doneFault`=1 and `doneCause` equal to the request's cause.
- R3: When the translation port returns a nonzero `xlateCause`, the walk ends with `doneFault`=1 and `doneCause` equal to that value. No memory request or TLB write follows, and neither the refill counter nor `excVaddr` changes.
- R4: `memReqValid` with `memReqAddr` (the translated entry address) stays asserted until `memReqReady` is seen. Exactly one memory request is made per walk.
- R5: The refill counter resets to 0. Each TLB write first increments it and uses the low two bits of the new value, so successive writes after reset go to ways 1, 2, 3, 0, 1.
- R6: A TLB write carries the faulting address, the fetched entry word, ring = entry bits 5:4, and the request's instruction flag.
- R7: `excVaddr` resets to 0 and takes the faulting address only on a cycle that writes the TLB.
- R8: With `missUpdate`=0, a successful walk makes no TLB write, leaves the counter and `excVaddr` unchanged, and returns the entry and its ring on the completion pulse with `doneFault`=0 and `doneCause`=0.
- R9: `missReady` is high only when idle. Requests presented while busy are ignored, and `doneValid` is a single-cycle pulse that ends each walk.
- R10: During and right after reset the block is idle: `missReady`=1, and no translation, memory, write or done strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Miss request present |
| missReady | output | 1 | Walker idle, request accepted |
| missVaddr | input | 32 | Faulting virtual address |
| missInsn | input | 1 | 1 = instruction-side miss |
| missUpdate | input | 1 | 1 = write the fetched entry into the TLB |
| missCause | input | 4 | Lookup result code; 1 = plain miss |
| ptBase | input | 32 | Page-table base register |
| xlateValid | output | 1 | Translation request (data read, ring 0, no refill) |
| xlateVaddr | output | 32 | Entry virtual address to translate |
| xlatePaddr | input | 32 | Translated physical address |
| xlateCause | input | 4 | Translation fault cause, 0 = success |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | 32 | Physical entry address |
| memRespValid | input | 1 | Read data present |
| memRespData | input | 32 | Fetched entry word |
| tlbWrValid | output | 1 | TLB write strobe |
| tlbWrWay | output | 2 | Way to write |
| tlbWrVaddr | output | 32 | Faulting address for the new mapping |
| tlbWrPte | output | 32 | Entry word to install |
| tlbWrRing | output | 2 | Ring of the new mapping |
| tlbWrInsn | output | 1 | Selects instruction or data TLB |
| excVaddr | output | 32 | Exception virtual address register |
| doneValid | output | 1 | Walk complete pulse |
| doneFault | output | 1 | Walk ended in a fault |
| doneCause | output | 4 | Fault cause, 0 on success |
| donePte | output | 32 | Fetched entry word |
| doneRing | output | 2 | Ring field of the fetched entry |

## Verification
Several properties are checked on every cycle by the assertions. A pending memory request must hold until it is accepted. The completion strobe must last one cycle. A fault may never follow a memory request or a TLB write. The refill counter may only ever step by one. The exception address may change only after a committing write. The bench's scenarios are needed for the rest: the exact entry address arithmetic, the way rotation and its wrap from 3 to 0, and the values carried on the write and completion ports. They also show that non-miss causes and failed entry translations leave the counter and exception address alone, and that requests arriving mid-walk are dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE,
    ST_MEMREQ,
    ST_MEMWAIT,
    ST_WRITE,
    ST_DONE
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeReq;        // latch the incoming request
    logic takeXlateFault; // latch translation fault cause
    logic takePaddr;      // latch translated entry address
    logic takePte;        // latch fetched entry word
    logic commit;         // TLB write cycle: advance counter, record address
  } dpCtl_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   missValid,
  input  logic   isMiss,
  input  logic   xlateFault,
  input  logic   memReqReady,
  input  logic   memRespValid,
  input  logic   updLatched,
  output logic   missReady,
  output logic   xlateValid,
  output logic   memReqValid,
  output logic   tlbWrValid,
  output logic   doneValid,
  output dpCtl_t ctl
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    missReady   = 1'b0;
    xlateValid  = 1'b0;
    memReqValid = 1'b0;
    tlbWrValid  = 1'b0;
    doneValid   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        missReady = 1'b1;
        if (missValid) begin
          ctl.takeReq = 1'b1;
          stateNext   = isMiss ? ST_XLATE : ST_DONE;
        end
      end
      ST_XLATE: begin
        xlateValid = 1'b1;
        if (xlateFault) begin
          ctl.takeXlateFault = 1'b1;
          stateNext          = ST_DONE;
        end else begin
          ctl.takePaddr = 1'b1;
          stateNext     = ST_MEMREQ;
        end
      end
      ST_MEMREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRespValid) begin
          ctl.takePte = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        tlbWrValid = updLatched;
        ctl.commit = updLatched;
        stateNext  = ST_DONE;
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R4: an unaccepted request stays up
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WAYS  = 4,
  parameter int CAUSE_W   = 4,
  parameter int PTE_SHIFT = 10,
  parameter int RING_LSB  = 4,
  parameter int RING_W    = 2,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int ALIGN_W  = $clog2(DATA_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtl_t             ctl,
  input  logic [ADDR_W-1:0]  missVaddr,
  input  logic               missInsn,
  input  logic               missUpdate,
  input  logic [CAUSE_W-1:0] missCause,
  input  logic               isMiss,
  input  logic [ADDR_W-1:0]  ptBase,
  input  logic [ADDR_W-1:0]  xlatePaddr,
  input  logic [CAUSE_W-1:0] xlateCause,
  input  logic [DATA_W-1:0]  memRespData,
  output logic               updLatched,
  output logic [ADDR_W-1:0]  xlateVaddr,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [WAY_W-1:0]   tlbWrWay,
  output logic [ADDR_W-1:0]  tlbWrVaddr,
  output logic [DATA_W-1:0]  tlbWrPte,
  output logic [RING_W-1:0]  tlbWrRing,
  output logic               tlbWrInsn,
  output logic [ADDR_W-1:0]  excVaddr,
  output logic               doneFault,
  output logic [CAUSE_W-1:0] doneCause,
  output logic [DATA_W-1:0]  donePte,
  output logic [RING_W-1:0]  doneRing
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

  logic [ADDR_W-1:0]  vaddrReg, baseReg, paddrReg;
  logic [DATA_W-1:0]  pteReg;
  logic               insnReg, updReg, faultReg;
  logic [CAUSE_W-1:0] causeReg;
  logic [WAY_W-1:0]   wayCnt;
  logic [WAY_W-1:0]   wayNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddrReg <= '0;
      baseReg  <= '0;
      paddrReg <= '0;
      pteReg   <= '0;
      insnReg  <= 1'b0;
      updReg   <= 1'b0;
      faultReg <= 1'b0;
      causeReg <= '0;
    end else begin
      if (ctl.takeReq) begin
        vaddrReg <= missVaddr;
        baseReg  <= ptBase;
        insnReg  <= missInsn;
        updReg   <= missUpdate;
        faultReg <= !isMiss;
        causeReg <= isMiss ? '0 : missCause;
      end
      if (ctl.takeXlateFault) begin
        faultReg <= 1'b1;
        causeReg <= xlateCause;
      end
      if (ctl.takePaddr) paddrReg <= xlatePaddr;
      if (ctl.takePte)   pteReg   <= memRespData;
    end
  end

  // Pre-incremented way counter and exception address
  assign wayNext = wayCnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wayCnt   <= '0;
      excVaddr <= '0;
    end else if (ctl.commit) begin
      wayCnt   <= wayNext;
      excVaddr <= vaddrReg;
    end
  end

  assign xlateVaddr = (baseReg | (vaddrReg >> PTE_SHIFT)) & ALIGN_MASK;
  assign memReqAddr = paddrReg;
  assign updLatched = updReg;
  assign tlbWrWay   = wayNext;
  assign tlbWrVaddr = vaddrReg;
  assign tlbWrPte   = pteReg;
  assign tlbWrRing  = pteReg[RING_LSB +: RING_W];
  assign tlbWrInsn  = insnReg;
  assign doneFault  = faultReg;
  assign doneCause  = causeReg;
  assign donePte    = pteReg;
  assign doneRing   = pteReg[RING_LSB +: RING_W];

  // R5: each commit advances the counter by exactly one
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |=> wayCnt == WAY_W'($past(wayCnt) + 1'b1));

  // R7: the exception address only moves after a committing write
  a_r7_excv_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(excVaddr) |-> $past(ctl.commit));

endmodule

// File: rtl/pte_refill_walker.sv
module pte_refill_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WAYS  = 4,
  parameter int CAUSE_W   = 4,
  parameter int MISS_CODE = 1,
  parameter int PTE_SHIFT = 10,
  parameter int RING_LSB  = 4,
  parameter int RING_W    = 2,
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               missValid,
  output logic               missReady,
  input  logic [ADDR_W-1:0]  missVaddr,
  input  logic               missInsn,
  input  logic               missUpdate,
  input  logic [CAUSE_W-1:0] missCause,
  input  logic [ADDR_W-1:0]  ptBase,
  output logic               xlateValid,
  output logic [ADDR_W-1:0]  xlateVaddr,
  input  logic [ADDR_W-1:0]  xlatePaddr,
  input  logic [CAUSE_W-1:0] xlateCause,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRespValid,
  input  logic [DATA_W-1:0]  memRespData,
  output logic               tlbWrValid,
  output logic [WAY_W-1:0]   tlbWrWay,
  output logic [ADDR_W-1:0]  tlbWrVaddr,
  output logic [DATA_W-1:0]  tlbWrPte,
  output logic [RING_W-1:0]  tlbWrRing,
  output logic               tlbWrInsn,
  output logic [ADDR_W-1:0]  excVaddr,
  output logic               doneValid,
  output logic               doneFault,
  output logic [CAUSE_W-1:0] doneCause,
  output logic [DATA_W-1:0]  donePte,
  output logic [RING_W-1:0]  doneRing
);

  dpCtl_t ctl;
  logic   isMiss;
  logic   xlateFault;
  logic   updLatched;

  assign isMiss     = (missCause == CAUSE_W'(MISS_CODE));
  assign xlateFault = |xlateCause;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .missValid    (missValid),
    .isMiss       (isMiss),
    .xlateFault   (xlateFault),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .updLatched   (updLatched),
    .missReady    (missReady),
    .xlateValid   (xlateValid),
    .memReqValid  (memReqValid),
    .tlbWrValid   (tlbWrValid),
    .doneValid    (doneValid),
    .ctl          (ctl)
  );

  ptw_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_WAYS  (NUM_WAYS),
    .CAUSE_W   (CAUSE_W),
    .PTE_SHIFT (PTE_SHIFT),
    .RING_LSB  (RING_LSB),
    .RING_W    (RING_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .missVaddr   (missVaddr),
    .missInsn    (missInsn),
    .missUpdate  (missUpdate),
    .missCause   (missCause),
    .isMiss      (isMiss),
    .ptBase      (ptBase),
    .xlatePaddr  (xlatePaddr),
    .xlateCause  (xlateCause),
    .memRespData (memRespData),
    .updLatched  (updLatched),
    .xlateVaddr  (xlateVaddr),
    .memReqAddr  (memReqAddr),
    .tlbWrWay    (tlbWrWay),
    .tlbWrVaddr  (tlbWrVaddr),
    .tlbWrPte    (tlbWrPte),
    .tlbWrRing   (tlbWrRing),
    .tlbWrInsn   (tlbWrInsn),
    .excVaddr    (excVaddr),
    .doneFault   (doneFault),
    .doneCause   (doneCause),
    .donePte     (donePte),
    .doneRing    (doneRing)
  );

  // R2: a fault never follows a memory request
  a_r2_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneFault |-> !$past(memReqValid));

  // R3: a fault never follows a TLB write
  a_r3_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneFault |-> !$past(tlbWrValid));

endmodule

// File: tb/pte_refill_walker_test.sv
`timescale 1ns/1ps
module pte_refill_walker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        missValid, missReady, missInsn, missUpdate;
  logic [31:0] missVaddr, ptBase;
  logic [3:0]  missCause;
  logic        xlateValid;
  logic [31:0] xlateVaddr, xlatePaddr;
  logic [3:0]  xlateCause;
  logic        memReqValid, memReqReady, memRespValid;
  logic [31:0] memReqAddr, memRespData;
  logic        tlbWrValid, tlbWrInsn;
  logic [1:0]  tlbWrWay, tlbWrRing;
  logic [31:0] tlbWrVaddr, tlbWrPte, excVaddr;
  logic        doneValid, doneFault;
  logic [3:0]  doneCause;
  logic [31:0] donePte;
  logic [1:0]  doneRing;

  always #4 clk = ~clk;

  pte_refill_walker uut (.*);

  typedef struct {
    logic [31:0] va;
    logic [31:0] base;
    logic [3:0]  cause;
    logic        insn;
    logic        upd;
    int          lat;
  } stim_t;

  stim_t stims[$];
  int nChecks = 0;
  int nErrors = 0;
  bit running = 0;
  bit finished = 0;

  // reference model state
  int          mst = 0;   // 0 idle 1 xlate 2 memreq 3 memwait 4 write 5 done
  int          stimIdx = 0;
  int          waitCnt = 0;
  int          mCnt = 0;
  int          mLat = 0;
  logic [31:0] mVa = '0, mBase = '0, mPaddr = '0, mPte = '0, mExcv = '0;
  logic [3:0]  mCause = '0;
  logic        mFault = 0, mInsn = 0, mUpd = 0;
  logic [1:0]  waysSeen[$];

  function automatic logic [31:0] entryAddr(input logic [31:0] b, input logic [31:0] v);
    return (b | (v >> 10)) & 32'hFFFF_FFFC;
  endfunction
  function automatic logic [31:0] xlMap(input logic [31:0] a);
    return a ^ 32'h0100_0000;
  endfunction
  function automatic logic [3:0] xlFault(input logic [31:0] a);
    return (a[31:28] == 4'hF) ? 4'd7 : 4'd0;
  endfunction
  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0000_00A0;
  endfunction

  // TLB translation responder
  assign xlatePaddr = xlMap(xlateVaddr);
  assign xlateCause = xlFault(xlateVaddr);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      // compare outputs against the model
      chk(32'(missReady),   32'(mst == 0), "R9 missReady");
      chk(32'(xlateValid),  32'(mst == 1), "R1 xlateValid");
      if (mst == 1) chk(xlateVaddr, entryAddr(mBase, mVa), "R1 entry address");
      chk(32'(memReqValid), 32'(mst == 2), "R4 memReqValid");
      if (mst == 2) chk(memReqAddr, mPaddr, "R4 memReqAddr");
      chk(32'(tlbWrValid),  32'(mst == 4 && mUpd), "R8 tlbWrValid");
      if (mst == 4 && mUpd) begin
        chk(32'(tlbWrWay), 32'((mCnt + 1) % 4), "R5 way");
        chk(tlbWrVaddr, mVa, "R6 write vaddr");
        chk(tlbWrPte, mPte, "R6 write entry");
        chk(32'(tlbWrRing), 32'(mPte[5:4]), "R6 write ring");
        chk(32'(tlbWrInsn), 32'(mInsn), "R6 write insn flag");
        waysSeen.push_back(tlbWrWay);
      end
      chk(32'(doneValid), 32'(mst == 5), "R9 doneValid");
      if (mst == 5) begin
        chk(32'(doneFault), 32'(mFault), "R2 R3 doneFault");
        chk(32'(doneCause), 32'(mCause), "R2 R3 doneCause");
        if (!mFault) begin
          chk(donePte, mPte, "R8 donePte");
          chk(32'(doneRing), 32'(mPte[5:4]), "R6 doneRing");
        end
      end
      chk(excVaddr, mExcv, "R7 excVaddr");

      // drive next inputs and advance the model
      missValid    = 1'b0;
      memReqReady  = 1'b0;
      memRespValid = 1'b0;
      memRespData  = 32'h0;
      case (mst)
        0: begin
          if (stimIdx < stims.size()) begin
            stim_t s;
            s = stims[stimIdx];
            stimIdx++;
            missValid  = 1'b1;
            missVaddr  = s.va;
            ptBase     = s.base;
            missCause  = s.cause;
            missInsn   = s.insn;
            missUpdate = s.upd;
            mVa = s.va; mBase = s.base; mInsn = s.insn; mUpd = s.upd; mLat = s.lat;
            waitCnt = 0;
            if (s.cause == 4'd1) begin
              mFault = 0; mCause = 0; mst = 1;
            end else begin
              mFault = 1; mCause = s.cause; mst = 5;
            end
          end
        end
        1: begin
          logic [3:0] f;
          f = xlFault(entryAddr(mBase, mVa));
          if (f != 0) begin
            mFault = 1; mCause = f; mst = 5;
          end else begin
            mPaddr = xlMap(entryAddr(mBase, mVa)); mst = 2;
          end
        end
        2: begin
          if (waitCnt >= mLat) begin memReqReady = 1'b1; mst = 3; waitCnt = 0; end
          else waitCnt++;
        end
        3: begin
          if (waitCnt >= mLat) begin
            memRespValid = 1'b1;
            memRespData  = memWord(mPaddr);
            mPte = memWord(mPaddr);
            mst = 4;
          end else waitCnt++;
        end
        4: begin
          if (mUpd) begin mCnt++; mExcv = mVa; end
          mst = 5;
        end
        default: mst = 0;
      endcase
      // R9: junk requests while busy must be ignored
      if (mst != 0 && !missValid && stimIdx < stims.size()) begin
        missValid = 1'b1;
        missVaddr = 32'hDEAD_0000;
        missCause = 4'd1;
        missUpdate = 1'b1;
      end
    end
  end

  function automatic stim_t mk(input logic [31:0] va, input logic [31:0] base,
                               input logic [3:0] cause, input logic insn,
                               input logic upd, input int lat);
    stim_t s;
    s.va = va; s.base = base; s.cause = cause; s.insn = insn; s.upd = upd; s.lat = lat;
    return s;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    missValid = 0; missVaddr = 0; missInsn = 0; missUpdate = 0; missCause = 0; ptBase = 0;
    memReqReady = 0; memRespValid = 0; memRespData = 0;
    stims.push_back(mk(32'h1234_5678, 32'h8000_0000, 4'd1, 1'b0, 1'b1, 0)); // way 1
    stims.push_back(mk(32'hFFFF_FFFF, 32'h8000_0000, 4'd1, 1'b1, 1'b1, 3)); // way 2
    stims.push_back(mk(32'h0000_4000, 32'h8000_0000, 4'd2, 1'b0, 1'b1, 0)); // R2 multi-hit
    stims.push_back(mk(32'h0000_8000, 32'h8000_0000, 4'd3, 1'b1, 1'b1, 0)); // R2 privilege
    stims.push_back(mk(32'h0ABC_0000, 32'hF000_0000, 4'd1, 1'b0, 1'b1, 0)); // R3 xlate fault
    stims.push_back(mk(32'h7654_3210, 32'h8000_0000, 4'd1, 1'b0, 1'b0, 1)); // R8 no update
    stims.push_back(mk(32'h0000_1000, 32'h8000_0000, 4'd1, 1'b0, 1'b1, 2)); // way 3
    stims.push_back(mk(32'h4000_0030, 32'h9000_0000, 4'd1, 1'b1, 1'b1, 0)); // way 0
    stims.push_back(mk(32'hC003_0000, 32'h8000_0000, 4'd1, 1'b0, 1'b1, 2)); // way 1
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(32'(missReady),   32'd1, "R10 missReady in reset");
    chk(32'(xlateValid),  32'd0, "R10 xlateValid in reset");
    chk(32'(memReqValid), 32'd0, "R10 memReqValid in reset");
    chk(32'(tlbWrValid),  32'd0, "R10 tlbWrValid in reset");
    chk(32'(doneValid),   32'd0, "R10 doneValid in reset");
    chk(excVaddr,         32'd0, "R7 excVaddr reset value");
    rst_n = 1'b1;
    @(posedge clk);
    running = 1;
    wait (stimIdx == stims.size() && mst == 0);
    repeat (3) @(negedge clk);
    running = 0;
    // R5: rotation sequence after reset
    chk(32'(waysSeen.size()), 32'd5, "R5 number of writes");
    if (waysSeen.size() == 5) begin
      chk(32'(waysSeen[0]), 32'd1, "R5 first way");
      chk(32'(waysSeen[1]), 32'd2, "R5 second way");
      chk(32'(waysSeen[2]), 32'd3, "R5 third way");
      chk(32'(waysSeen[3]), 32'd0, "R5 wrap way");
      chk(32'(waysSeen[4]), 32'd1, "R5 fifth way");
    end
    chk(excVaddr, 32'hC003_0000, "R7 final excVaddr");
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", stimIdx, stims.size());
      finish_run();
    end
  end

endmodule